// File: doc/BRIEF.md
# Branch and Call Program-Counter Sequencer

This block owns the program counter of a small controller that has 16-bit instruction words and 8-bit data. Instruction words arrive one at a time on a valid/ready stream. The block accepts a word only when both `in_valid` and `in_ready` are high at a rising clock edge. While `in_ready` is low the word on `in_word` is not consumed, and the source must hold it. The PC always holds the byte address of the next word to be accepted, and its bit 0 is always zero.

Two opcodes change control flow. The first is a one-word relative branch that is taken when the Zero flag is set. The second is a two-word absolute subroutine call. The call pushes a return address onto an internal return stack. It can also copy the working register, the status register and the bank-select register into shadow copies. Every other word only advances the PC.

A taken branch is followed by one idle cycle, during which no word is accepted. A completed call raises `flush` for one cycle, which tells the fetch side to fetch again from the new PC. The ALU, the data memory and the return opcode are outside this block.

Top module: `flow_seq`

## Requirements
- R1: A synchronous reset sets the PC, the stack level, the overflow flag and all three shadow registers to zero. After reset `in_ready` is 1 and both `flush` and `idle_cycle` are 0.
- R2: An accepted word that is neither a branch nor a first call word advances the PC by 2. This includes a word whose top nibble is 4'hF when it does not follow a first call word. Such a word changes neither the stack nor the shadow registers.
- R3: A word with bits [15:8] = 8'hE0 is the branch, and bits [7:0] hold a signed word offset n. When it is accepted with `zero_flag` = 1, the next PC is (PC + 2 + 2n) mod 2^21 and `flush` is 1 for the following cycle.
- R4: A taken branch is followed by exactly one idle cycle. In that cycle `idle_cycle` is 1, `in_ready` is 0, and a word held on the input is not consumed. The word is accepted in the cycle after.
- R5: When the branch is accepted with `zero_flag` = 0, the PC becomes PC + 2 and no idle cycle follows.
- R6: A word with bits [15:9] = 7'b1110110 is the first call word. Its bit 8 is the save flag s, and its bits [7:0] are k[7:0]. The next accepted word supplies k[19:8] in its bits [11:0], and the block ignores its top nibble. When that second word is accepted, the PC becomes {k, 1'b0}, the address of the first call word plus 4 is pushed and appears on `tos`, `stack_level` rises by 1, and `push_strobe` and `flush` pulse for one cycle with `push_addr` carrying the pushed value.
- R7: When s = 1, the shadow registers load the values that `w_reg`, `status_reg` and `bsr_reg` hold in the cycle the second call word is accepted. When s = 0, the shadow registers keep their values.
- R8: The stack holds 31 entries. A push onto a full stack sets `stack_ovf`, which stays set until reset, and leaves `stack_level` and `tos` unchanged.
- R9: A cycle without an accepted word leaves the PC unchanged.
- R10: After a first call word, gaps in `in_valid` do not cancel the call. The next accepted word completes the call, and the PC holds the address of the first call word plus 2 until that word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 16 | Instruction word |
| zero_flag | input | 1 | Zero flag from the ALU |
| w_reg | input | 8 | Current working register |
| status_reg | input | 8 | Current status register |
| bsr_reg | input | 4 | Current bank-select register |
| pc | output | 21 | Byte address of next word to accept |
| flush | output | 1 | One-cycle pulse after a redirect |
| idle_cycle | output | 1 | Idle cycle after a taken branch |
| push_strobe | output | 1 | One-cycle pulse after a stack push attempt |
| push_addr | output | 21 | Return address of the last push attempt |
| tos | output | 21 | Top of the return stack (0 when empty) |
| stack_level | output | 5 | Number of stacked entries |
| stack_ovf | output | 1 | Sticky overflow flag |
| shadow_w | output | 8 | Shadow copy of W |
| shadow_status | output | 8 | Shadow copy of STATUS |
| shadow_bsr | output | 4 | Shadow copy of BSR |

## Verification
A corrupted sequencer state shows at the ports within one cycle. A missed or extra idle cycle appears as a wrong `in_ready` right after the branch. A lost half-call leaves the PC stepping by 2 where it should jump, and that shows on the cycle after the second word. Stack pointer errors show on `tos` and `stack_level` on the cycle after the push. Wrong shadow capture timing shows when the W, STATUS and BSR inputs change between the two call words. The bench sweeps all 256 branch offsets with the flag both set and clear. It also runs a series of calls with both save settings and fills the stack past its capacity.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;
  localparam int WORD_W = 16;
  localparam logic [7:0] BRZ_OPC  = 8'hE0;
  localparam logic [6:0] CALL_OPC = 7'b1110110;

  typedef enum logic [1:0] {K_SEQ, K_BRZ, K_CALL} word_kind_e;
  typedef enum logic [1:0] {ST_RUN, ST_CALL_HI, ST_BUBBLE} seq_state_e;

  typedef struct packed {
    word_kind_e kind;
    logic       save;
    logic [7:0] lit;
  } decoded_t;
endpackage

// File: rtl/flow_seq_decode.sv
module flow_seq_decode
  import flow_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output decoded_t          dec
);
  always_comb begin
    dec.lit  = word[7:0];
    dec.save = 1'b0;
    if (word[15:8] == BRZ_OPC) begin
      dec.kind = K_BRZ;
    end else if (word[15:9] == CALL_OPC) begin
      dec.kind = K_CALL;
      dec.save = word[8];
    end else begin
      dec.kind = K_SEQ;
    end
  end
endmodule

// File: rtl/flow_seq_stack.sv
module flow_seq_stack #(
  parameter int ADDR_W = 21,
  parameter int DEPTH  = 31,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_val,
  output logic [ADDR_W-1:0] tos,
  output logic [LVL_W-1:0]  level,
  output logic              ovf
);
  logic [ADDR_W-1:0] mem [DEPTH];
  logic              full;

  assign full = (level == LVL_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (full) begin
        ovf <= 1'b1;
      end else begin
        level <= level + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && push && !full) mem[level] <= push_val;
  end

  assign tos = (level == '0) ? '0 : mem[level - 1'b1];

  assert_level_cap_R8: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_full_push_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ($stable(level) && $stable(tos)));
  assert_push_step_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (level == $past(level) + 1'b1 && tos == $past(push_val)));
endmodule

// File: rtl/flow_seq_shadow.sv
module flow_seq_shadow #(
  parameter int DATA_W = 8,
  parameter int BSR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [BSR_W-1:0]  bsr_in,
  output logic [DATA_W-1:0] w_sh,
  output logic [DATA_W-1:0] status_sh,
  output logic [BSR_W-1:0]  bsr_sh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      w_sh      <= '0;
      status_sh <= '0;
      bsr_sh    <= '0;
    end else if (we) begin
      w_sh      <= w_in;
      status_sh <= status_in;
      bsr_sh    <= bsr_in;
    end
  end

  assert_shadow_keep_R7: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(w_sh) && $stable(status_sh) && $stable(bsr_sh)));
  assert_shadow_load_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> (w_sh == $past(w_in) && bsr_sh == $past(bsr_in)));
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_seq_pkg::*;
#(
  parameter int PC_W        = 21,
  parameter int STACK_DEPTH = 31,
  parameter int DATA_W      = 8,
  parameter int BSR_W       = 4,
  localparam int LVL_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_word,
  input  logic              zero_flag,
  input  logic [DATA_W-1:0] w_reg,
  input  logic [DATA_W-1:0] status_reg,
  input  logic [BSR_W-1:0]  bsr_reg,
  output logic [PC_W-1:0]   pc,
  output logic              flush,
  output logic              idle_cycle,
  output logic              push_strobe,
  output logic [PC_W-1:0]   push_addr,
  output logic [PC_W-1:0]   tos,
  output logic [LVL_W-1:0]  stack_level,
  output logic              stack_ovf,
  output logic [DATA_W-1:0] shadow_w,
  output logic [DATA_W-1:0] shadow_status,
  output logic [BSR_W-1:0]  shadow_bsr
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  seq_state_e        state;
  decoded_t          dec;
  logic              accept;
  logic              commit;
  logic [7:0]        k_lo;
  logic              save_q;
  logic [PC_W-1:0]   br_target;
  logic [PC_W-1:0]   call_target;
  logic [PC_W-1:0]   ret_addr;

  flow_seq_decode u_dec (.word(in_word), .dec(dec));

  assign in_ready    = (state != ST_BUBBLE);
  assign idle_cycle  = (state == ST_BUBBLE);
  assign accept      = in_valid && in_ready;
  assign commit      = accept && (state == ST_CALL_HI);
  assign br_target   = pc + STEP + {{(PC_W-9){dec.lit[7]}}, dec.lit, 1'b0};
  assign call_target = PC_W'({in_word[11:0], k_lo, 1'b0});
  assign ret_addr    = pc + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      state       <= ST_RUN;
      k_lo        <= '0;
      save_q      <= 1'b0;
      flush       <= 1'b0;
      push_strobe <= 1'b0;
      push_addr   <= '0;
    end else begin
      flush       <= 1'b0;
      push_strobe <= 1'b0;
      unique case (state)
        ST_RUN: if (accept) begin
          unique case (dec.kind)
            K_BRZ: if (zero_flag) begin
              pc    <= br_target;
              flush <= 1'b1;
              state <= ST_BUBBLE;
            end else begin
              pc <= pc + STEP;
            end
            K_CALL: begin
              pc     <= pc + STEP;
              k_lo   <= dec.lit;
              save_q <= dec.save;
              state  <= ST_CALL_HI;
            end
            default: pc <= pc + STEP;
          endcase
        end
        ST_CALL_HI: if (accept) begin
          pc          <= call_target;
          flush       <= 1'b1;
          push_strobe <= 1'b1;
          push_addr   <= ret_addr;
          state       <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  flow_seq_stack #(.ADDR_W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(commit), .push_val(ret_addr),
    .tos(tos), .level(stack_level), .ovf(stack_ovf)
  );

  flow_seq_shadow #(.DATA_W(DATA_W), .BSR_W(BSR_W)) u_shadow (
    .clk(clk), .rst(rst), .we(commit && save_q),
    .w_in(w_reg), .status_in(status_reg), .bsr_in(bsr_reg),
    .w_sh(shadow_w), .status_sh(shadow_status), .bsr_sh(shadow_bsr)
  );

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && state == ST_RUN && dec.kind == K_SEQ) |=> (pc == $past(pc) + STEP));
  assert_bubble_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && state == ST_RUN && dec.kind == K_BRZ && zero_flag)
      |=> (idle_cycle && !in_ready && flush));
  assert_bubble_once_R4: assert property (@(posedge clk) disable iff (rst)
    idle_cycle |=> in_ready);
  assert_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && state == ST_RUN && dec.kind == K_BRZ && !zero_flag)
      |=> (in_ready && pc == $past(pc) + STEP));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(pc));
  assert_call_flush_R6: assert property (@(posedge clk) disable iff (rst)
    commit |=> (flush && push_strobe));
endmodule

// File: tb/flow_seq_bench.sv
module flow_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MASK = 32'h1FFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        zero_flag = 1'b0;
  logic [7:0]  w_reg = '0;
  logic [7:0]  status_reg = '0;
  logic [3:0]  bsr_reg = '0;
  logic [20:0] pc;
  logic        flush, idle_cycle, push_strobe, stack_ovf;
  logic [20:0] push_addr, tos;
  logic [4:0]  stack_level;
  logic [7:0]  shadow_w, shadow_status;
  logic [3:0]  shadow_bsr;

  int checks = 0;
  int failures = 0;
  int exp_pc = 0;
  int exp_lvl = 0;
  int exp_tos = 0;
  int exp_sw = 0, exp_ss = 0, exp_sb = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_seq u_flow_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .zero_flag(zero_flag), .w_reg(w_reg),
    .status_reg(status_reg), .bsr_reg(bsr_reg), .pc(pc), .flush(flush),
    .idle_cycle(idle_cycle), .push_strobe(push_strobe), .push_addr(push_addr),
    .tos(tos), .stack_level(stack_level), .stack_ovf(stack_ovf),
    .shadow_w(shadow_w), .shadow_status(shadow_status), .shadow_bsr(shadow_bsr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exec(input logic [15:0] w, input logic z);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_word = w; zero_flag = z;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    exp_pc = 0; exp_lvl = 0; exp_tos = 0; exp_sw = 0; exp_ss = 0; exp_sb = 0;
  endtask

  task automatic call(input int k, input bit s, input int gap);
    int base;
    base = exp_pc;
    exec(16'hEC00 | (16'(s) << 8) | 16'(k & 8'hFF), 1'b0);
    chk("R10 pc after first call word", int'(pc), (base + 2) & MASK);
    repeat (gap) begin
      @(posedge clk); #1;
      chk("R10 pc held in call gap", int'(pc), (base + 2) & MASK);
    end
    w_reg = 8'(k * 7 + 3); status_reg = 8'(k ^ 8'h5A); bsr_reg = 4'(k + 1);
    exec(16'hF000 | 16'((k >> 8) & 12'hFFF), 1'b0);
    exp_pc = (k << 1) & MASK;
    if (exp_lvl < 31) begin exp_lvl++; exp_tos = (base + 4) & MASK; end
    if (s) begin exp_sw = (k * 7 + 3) & 8'hFF; exp_ss = (k ^ 8'h5A) & 8'hFF; exp_sb = (k + 1) & 4'hF; end
    w_reg = ~w_reg; status_reg = ~status_reg; bsr_reg = ~bsr_reg;
    chk("R6 call target pc", int'(pc), exp_pc);
    chk("R6 tos", int'(tos), exp_tos);
    chk("R6 stack level", int'(stack_level), exp_lvl);
    chk("R6 push strobe/flush", int'({push_strobe, flush}), 3);
    chk("R6 push addr", int'(push_addr), (base + 4) & MASK);
    chk("R7 shadow w", int'(shadow_w), exp_sw);
    chk("R7 shadow status", int'(shadow_status), exp_ss);
    chk("R7 shadow bsr", int'(shadow_bsr), exp_sb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 pc", int'(pc), 0);
    chk("R1 level/ovf", int'({stack_level, stack_ovf}), 0);
    chk("R1 shadows", int'({shadow_w, shadow_status, shadow_bsr}), 0);
    chk("R1 ready/flush/idle", int'({in_ready, flush, idle_cycle}), 4);

    // R2: plain words, lone second-call-style word, near-miss opcodes
    exec(16'h0000, 1'b1); exp_pc += 2; chk("R2 seq word", int'(pc), exp_pc);
    exec(16'hF123, 1'b1); exp_pc += 2; chk("R2 lone F word", int'(pc), exp_pc);
    chk("R2 lone F word no push", int'(stack_level), 0);
    exec(16'hE100, 1'b1); exp_pc += 2; chk("R2 near branch opcode", int'(pc), exp_pc);
    exec(16'hEE05, 1'b1); exp_pc += 2; chk("R2 near call opcode", int'(pc), exp_pc);

    // R9: idle input
    repeat (5) begin
      @(posedge clk); #1;
      chk("R9 pc stable without valid", int'(pc), exp_pc);
    end

    // R3/R4/R5: sweep all offsets both flag values
    for (int n = 0; n < 256; n++) begin
      for (int z = 0; z < 2; z++) begin
        int sn;
        sn = (n > 127) ? n - 256 : n;
        exec(16'hE000 | 16'(n), z[0]);
        if (z == 1) begin
          exp_pc = (exp_pc + 2 + 2 * sn) & MASK;
          chk("R3 taken target", int'(pc), exp_pc);
          chk("R4 idle/ready/flush", int'({idle_cycle, in_ready, flush}), 5);
        end else begin
          exp_pc = (exp_pc + 2) & MASK;
          chk("R5 not taken", int'(pc), exp_pc);
          chk("R5 no idle", int'({idle_cycle, in_ready}), 1);
        end
      end
    end

    // R4: word held during idle cycle is not consumed
    exec(16'hE010, 1'b1);
    exp_pc = (exp_pc + 2 + 32) & MASK;
    in_valid = 1'b1; in_word = 16'h1234;
    @(posedge clk); #1;
    chk("R4 word held in idle cycle", int'(pc), exp_pc);
    chk("R4 ready back", int'({in_ready, idle_cycle}), 2);
    @(posedge clk); #1;
    in_valid = 1'b0;
    exp_pc = (exp_pc + 2) & MASK;
    chk("R4 held word then accepted", int'(pc), exp_pc);

    // R6/R7/R10: calls with both save settings, some with gaps
    for (int i = 0; i < 12; i++) begin
      call((i * 32'h13579 + 32'h2468) & 32'hFFFFF, i[0], (i % 4 == 3) ? 3 : 0);
    end

    // R8: overflow
    do_reset();
    for (int i = 1; i <= 31; i++) call(i * 33, 1'b0, 0);
    chk("R8 full level", int'(stack_level), 31);
    chk("R8 no ovf yet", int'(stack_ovf), 0);
    call(20'hABCDE, 1'b0, 0);
    chk("R8 ovf set", int'(stack_ovf), 1);
    exec(16'h0000, 1'b0); exp_pc += 2;
    chk("R8 ovf sticky", int'(stack_ovf), 1);
    chk("R8 level after ovf", int'(stack_level), 31);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule